// File: doc/BRIEF.md
# Bidirectional Byte-Parity Transceiver Stage

This block moves a 16-bit word, together with one parity bit per byte, between an A side and a B side. Each direction has its own storage stage. It can pass the incoming word straight through, capture it on a rising edge of that direction's clock, or hold the last captured word while the clock is stopped.

On the way from A to B, a mode input selects one of two behaviours. In the first, the B-side parity bits are generated fresh from the data. In the second, the parity arriving with the A-side data is forwarded and checked. The way from B to A always forwards and checks.

A single polarity input selects odd or even parity for both ways at once. Each direction raises one merged, active-low error flag when either of its bytes is wrong. The flag is modelled as an open-drain pin: it only pulls low while that direction's outputs are enabled. Tri-state outputs are represented as a data value plus a separate drive-enable output.

Top module: `bidir_parity_xcvr`

## Requirements
- R1: With its latch-enable high, a direction is transparent: its data and parity outputs follow its inputs in the same cycle.
- R2: With its latch-enable low, a direction loads its 18-bit input word on the rising edge of its own clock and presents it after that edge.
- R3: With its latch-enable low and no edge on its clock, a direction holds its output word while its inputs change.
- R4: In A-to-B generate mode (gen_mode = 1), b_par_out[0] covers data bits 7:0 and b_par_out[1] covers bits 15:8. Each bit is chosen so that the byte plus its bit holds an odd count of ones when odd_sel = 1, and an even count when odd_sel = 0.
- R5: In A-to-B check mode (gen_mode = 0), b_par_out carries the A-side parity bits held in or passing through the storage stage.
- R6: In check mode, err_ab_n goes low while oe_ab_n is low and either stored A-side byte disagrees with its parity bit. In generate mode, err_ab_n never goes low.
- R7: The B-to-A direction never generates parity. a_par_out carries the B-side parity bits, and err_ba_n goes low while oe_ba_n is low and either stored byte disagrees with its parity bit.
- R8: The output enables are active low. b_drive equals the inverse of oe_ab_n and a_drive equals the inverse of oe_ba_n. While a direction's enable is high, its error flag reads 1.
- R9: odd_sel sets the parity sense for generation and checking in both directions at the same time.
- R10: rst_n low clears both storage stages to zero asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both storage stages |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even, for both directions |
| gen_mode | input | 1 | 1 generates B-side parity, 0 forwards and checks A-side parity |
| clk_ab | input | 1 | Capture clock, A to B |
| le_ab | input | 1 | Transparent when high, A to B |
| oe_ab_n | input | 1 | Active-low output enable of the B side |
| a_data_in | input | 16 | Data arriving from the A side |
| a_par_in | input | 2 | Byte parity arriving from the A side |
| b_data_out | output | 16 | Data toward the B side |
| b_par_out | output | 2 | Byte parity toward the B side |
| b_drive | output | 1 | 1 while the B-side outputs are driven |
| err_ab_n | output | 1 | Open-drain style error flag, A to B, low on error |
| clk_ba | input | 1 | Capture clock, B to A |
| le_ba | input | 1 | Transparent when high, B to A |
| oe_ba_n | input | 1 | Active-low output enable of the A side |
| b_data_in | input | 16 | Data arriving from the B side |
| b_par_in | input | 2 | Byte parity arriving from the B side |
| a_data_out | output | 16 | Data toward the A side |
| a_par_out | output | 2 | Byte parity toward the A side |
| a_drive | output | 1 | 1 while the A-side outputs are driven |
| err_ba_n | output | 1 | Open-drain style error flag, B to A, low on error |

## Verification
The interesting collision is a clock edge that loads a word with a corrupted byte while, in that same cycle, the output enable or the storage mode of the direction changes. In that cycle the error flag must follow the newly captured word and, at the same time, obey the enable gating. The bench provokes this by randomising the enable and injecting a single flipped bit into either byte, or into a parity bit, on every cycle of each mode. It sweeps both parity senses and both A-to-B modes. A behavioural model holds its own copy of each stored word and predicts every output, flag and drive bit, and the bench compares them on each falling edge.

// File: rtl/bidir_parity_xcvr.sv
module bidir_parity_xcvr #(
  parameter int DW = 16
) (
  input  logic               rst_n,
  input  logic               odd_sel,
  input  logic               gen_mode,
  input  logic               clk_ab,
  input  logic               le_ab,
  input  logic               oe_ab_n,
  input  logic [DW-1:0]      a_data_in,
  input  logic [DW/8-1:0]    a_par_in,
  output logic [DW-1:0]      b_data_out,
  output logic [DW/8-1:0]    b_par_out,
  output logic               b_drive,
  output logic               err_ab_n,
  input  logic               clk_ba,
  input  logic               le_ba,
  input  logic               oe_ba_n,
  input  logic [DW-1:0]      b_data_in,
  input  logic [DW/8-1:0]    b_par_in,
  output logic [DW-1:0]      a_data_out,
  output logic [DW/8-1:0]    a_par_out,
  output logic               a_drive,
  output logic               err_ba_n
);
  localparam int NB = DW / 8;
  localparam int WW = DW + NB;

  logic [WW-1:0] q_ab, q_ba, w_ab, w_ba;
  logic [NB-1:0] gen_par, bad_ab, bad_ba;

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) q_ab <= '0;
    else        q_ab <= {a_par_in, a_data_in};

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) q_ba <= '0;
    else        q_ba <= {b_par_in, b_data_in};

  assign w_ab = le_ab ? {a_par_in, a_data_in} : q_ab;
  assign w_ba = le_ba ? {b_par_in, b_data_in} : q_ba;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign gen_par[i] = (^w_ab[8*i +: 8]) ^ odd_sel;
    assign bad_ab[i]  = (^w_ab[8*i +: 8]) ^ w_ab[DW+i] ^ odd_sel;
    assign bad_ba[i]  = (^w_ba[8*i +: 8]) ^ w_ba[DW+i] ^ odd_sel;
  end

  assign b_data_out = w_ab[DW-1:0];
  assign b_par_out  = gen_mode ? gen_par : w_ab[DW +: NB];
  assign b_drive    = ~oe_ab_n;
  assign err_ab_n   = ~(~oe_ab_n & ~gen_mode & (|bad_ab));

  assign a_data_out = w_ba[DW-1:0];
  assign a_par_out  = w_ba[DW +: NB];
  assign a_drive    = ~oe_ba_n;
  assign err_ba_n   = ~(~oe_ba_n & (|bad_ba));
endmodule

module bidir_parity_xcvr_chk #(
  parameter int DW = 16
) (
  input logic            rst_n,
  input logic            odd_sel,
  input logic            gen_mode,
  input logic            clk_ab,
  input logic            le_ab,
  input logic            oe_ab_n,
  input logic [DW-1:0]   a_data_in,
  input logic [DW-1:0]   b_data_out,
  input logic [DW/8-1:0] b_par_out,
  input logic            err_ab_n,
  input logic            clk_ba,
  input logic            le_ba,
  input logic            oe_ba_n,
  input logic [DW-1:0]   b_data_in,
  input logic [DW-1:0]   a_data_out,
  input logic            err_ba_n
);
  localparam int NB = DW / 8;

  assert_ab_transparent_R1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    le_ab |-> b_data_out == a_data_in);
  assert_ba_transparent_R1: assert property (@(posedge clk_ba) disable iff (!rst_n)
    le_ba |-> a_data_out == b_data_in);
  assert_ab_captured_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!le_ab && $past(rst_n)) |-> b_data_out == $past(a_data_in));
  assert_ba_captured_R2: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!le_ba && $past(rst_n)) |-> a_data_out == $past(b_data_in));
  assert_gen_low_byte_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    gen_mode |-> (^{b_par_out[0], b_data_out[7:0]}) == odd_sel);
  assert_gen_high_byte_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    gen_mode |-> (^{b_par_out[NB-1], b_data_out[DW-1 -: 8]}) == odd_sel);
  assert_gen_no_error_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
    gen_mode |-> err_ab_n);
  assert_ab_flag_released_R8: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_ab_n |-> err_ab_n);
  assert_ba_flag_released_R8: assert property (@(posedge clk_ba) disable iff (!rst_n)
    oe_ba_n |-> err_ba_n);
endmodule

bind bidir_parity_xcvr bidir_parity_xcvr_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_bidir_parity_xcvr.sv
module tb_bidir_parity_xcvr;
  logic sclk = 1'b0;
  always #4 sclk = ~sclk;

  logic rst_n, odd_sel, gen_mode;
  logic le_ab, en_ab, oe_ab_n, le_ba, en_ba, oe_ba_n;
  logic [15:0] a_data_in, b_data_in, b_data_out, a_data_out;
  logic [1:0]  a_par_in, b_par_in, b_par_out, a_par_out;
  logic b_drive, a_drive, err_ab_n, err_ba_n;
  logic clk_ab, clk_ba;
  assign clk_ab = sclk & en_ab;
  assign clk_ba = sclk & en_ba;

  bidir_parity_xcvr dut (
    .rst_n(rst_n), .odd_sel(odd_sel), .gen_mode(gen_mode),
    .clk_ab(clk_ab), .le_ab(le_ab), .oe_ab_n(oe_ab_n),
    .a_data_in(a_data_in), .a_par_in(a_par_in),
    .b_data_out(b_data_out), .b_par_out(b_par_out), .b_drive(b_drive), .err_ab_n(err_ab_n),
    .clk_ba(clk_ba), .le_ba(le_ba), .oe_ba_n(oe_ba_n),
    .b_data_in(b_data_in), .b_par_in(b_par_in),
    .a_data_out(a_data_out), .a_par_out(a_par_out), .a_drive(a_drive), .err_ba_n(err_ba_n)
  );

  int compared = 0, mismatched = 0;
  bit done = 0, in_reset = 0;
  logic [17:0] m_ab, m_ba;

  always @(posedge sclk or negedge rst_n)
    if (!rst_n) begin m_ab <= '0; m_ba <= '0; end
    else begin
      if (en_ab) m_ab <= {a_par_in, a_data_in};
      if (en_ba) m_ba <= {b_par_in, b_data_in};
    end

  function automatic int ones(input logic [7:0] b);
    int c = 0;
    for (int k = 0; k < 8; k++) c += b[k];
    return c;
  endfunction

  function automatic logic good_bit(input logic [7:0] b, input logic odd);
    return odd ? ((ones(b) % 2) == 0) : ((ones(b) % 2) == 1);
  endfunction

  function automatic logic is_bad(input logic [7:0] b, input logic p, input logic odd);
    return ((ones(b) + p) % 2) != odd;
  endfunction

  function automatic logic [17:0] make_word(input logic [15:0] d, input logic odd, input int inj);
    logic [17:0] w;
    w = {good_bit(d[15:8], odd), good_bit(d[7:0], odd), d};
    case (inj)
      1: w[$urandom_range(7, 0)] ^= 1'b1;
      2: w[$urandom_range(15, 8)] ^= 1'b1;
      3: w[16 + $urandom_range(1, 0)] ^= 1'b1;
      default: ;
    endcase
    return w;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [17:0] w_ab, w_ba;
    logic [1:0] ep;
    logic eab, eba;
    string t_d_ab, t_d_ba;
    w_ab = le_ab ? {a_par_in, a_data_in} : m_ab;
    w_ba = le_ba ? {b_par_in, b_data_in} : m_ba;
    ep = gen_mode ? {good_bit(w_ab[15:8], odd_sel), good_bit(w_ab[7:0], odd_sel)} : w_ab[17:16];
    eab = !(!oe_ab_n && !gen_mode && (is_bad(w_ab[7:0], w_ab[16], odd_sel) || is_bad(w_ab[15:8], w_ab[17], odd_sel)));
    eba = !(!oe_ba_n && (is_bad(w_ba[7:0], w_ba[16], odd_sel) || is_bad(w_ba[15:8], w_ba[17], odd_sel)));
    t_d_ab = in_reset ? "R10" : le_ab ? "R1" : en_ab ? "R2" : "R3";
    t_d_ba = in_reset ? "R10" : le_ba ? "R1" : en_ba ? "R2" : "R3";
    cmp(t_d_ab, "b_data_out", b_data_out, w_ab[15:0]);
    cmp(gen_mode ? "R4 R9" : "R5", "b_par_out", b_par_out, ep);
    cmp(oe_ab_n ? "R8" : "R6 R9", "err_ab_n", err_ab_n, eab);
    cmp("R8", "b_drive", b_drive, !oe_ab_n);
    cmp(t_d_ba, "a_data_out", a_data_out, w_ba[15:0]);
    cmp("R7", "a_par_out", a_par_out, w_ba[17:16]);
    cmp(oe_ba_n ? "R8" : "R7 R9", "err_ba_n", err_ba_n, eba);
    cmp("R8", "a_drive", a_drive, !oe_ba_n);
  endtask

  task automatic randomize_inputs(input bit inject);
    logic [17:0] wa, wb;
    wa = make_word(16'($urandom), odd_sel, inject ? int'($urandom_range(3, 0)) : 0);
    wb = make_word(16'($urandom), odd_sel, inject ? int'($urandom_range(3, 0)) : 0);
    {a_par_in, a_data_in} = wa;
    {b_par_in, b_data_in} = wb;
    oe_ab_n = ($urandom_range(3, 0) == 0);
    oe_ba_n = ($urandom_range(3, 0) == 0);
  endtask

  task automatic set_mode(input int m, output logic le, output logic en);
    le = (m == 0);
    en = (m == 1);
  endtask

  initial begin
    repeat (200000) @(posedge sclk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_reset = 1; odd_sel = 1'b1; gen_mode = 1'b0;
    le_ab = 1'b0; en_ab = 1'b1; le_ba = 1'b0; en_ba = 1'b1;
    oe_ab_n = 1'b0; oe_ba_n = 1'b0;
    a_data_in = 16'hA5C3; a_par_in = 2'b11; b_data_in = 16'h3C5A; b_par_in = 2'b01;
    repeat (3) begin
      @(negedge sclk);
      check_all();
    end
    rst_n = 1'b1; in_reset = 0;
    for (int odd = 0; odd < 2; odd++)
      for (int g = 0; g < 2; g++)
        for (int m = 0; m < 3; m++) begin
          @(negedge sclk);
          check_all();
          odd_sel = 1'(odd);
          gen_mode = 1'(g);
          set_mode(m, le_ab, en_ab);
          set_mode((m + 1) % 3, le_ba, en_ba);
          randomize_inputs(1);
          repeat (30) begin
            @(negedge sclk);
            check_all();
            randomize_inputs(1);
          end
        end
    @(negedge sclk);
    check_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule